// File: doc/BRIEF.md
# Receive Buffer Fresh-Frame Status Vector

This block keeps one status flag for each of eight receive buffers. A flag goes high once the receive path has finished moving a complete frame from its staging area into that buffer. The flag stays high until the CPU acknowledges that buffer. The CPU reads all eight flags at once to find out which buffers hold frames it has not yet consumed. Any number of flags can be high together.

The flags are the per-buffer "fresh data" indications themselves, so the vector and each buffer's own flag always agree. Software cannot write the vector. A flag is cleared only by that buffer's acknowledge strobe, by the controller's init request, or by mask mode.

Two of the buffers, 0 and 2, can be switched into mask operation. While a buffer is in mask operation its flag has no meaning: the flag reads 0 and is not set. Each completed store also raises a one-cycle receive-interrupt pulse that carries the buffer index.

Top module: `rx_fresh_status`

## Requirements
- R1: The vector `newData` has eight independent bits, where bit n belongs to buffer n, and several bits can be 1 at the same time.
- R2: A cycle with `storeValid` high and buffer index `storeIdx` sets bit `storeIdx` of `newData`, and the bit is visible from the following cycle.
- R3: A high `ackVec[n]` with no store to buffer n clears bit n of `newData` from the following cycle.
- R4: A bit keeps its value in any cycle that has no store to it, no acknowledge of it, no init request and no mask mode on it.
- R5: Reset leaves `newData`, `rdData`, `irqPulse` and `irqIdx` at 0. A cycle with `initReq` high clears every bit from the next cycle, and init takes priority over a store in the same cycle.
- R6: Only buffers 0 and 2 can use mask mode, so `maskMode` bits 1 and 3 to 7 are ignored. While `maskMode[0]` or `maskMode[2]` is high, the matching bit reads 0 in the same cycle, stores to that buffer do not set it, and the stored flag is cleared.
- R7: A store and an acknowledge that target the same buffer in the same cycle leave the bit set.
- R8: For every store cycle without `initReq`, `irqPulse` is 1 in the next cycle only, and `irqIdx` carries that store's index. Otherwise `irqPulse` is 0.
- R9: A cycle with `rdEn` high copies the visible `newData` into `rdData` for the next cycle, and `rdData` holds its value when `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| initReq | input | 1 | Controller init request, clears all flags |
| storeValid | input | 1 | Frame fully moved into a buffer this cycle |
| storeIdx | input | 3 | Index of the buffer that was written |
| ackVec | input | 8 | Per-buffer CPU acknowledge strobes |
| maskMode | input | 8 | Mask-operation configuration per buffer (only bits 0 and 2 used) |
| rdEn | input | 1 | CPU read of the status vector |
| newData | output | 8 | Live fresh-frame status vector |
| rdData | output | 8 | Registered read data |
| irqPulse | output | 1 | One-cycle receive interrupt |
| irqIdx | output | 3 | Buffer index of the interrupt |

## Verification
The assertions assume that `storeIdx` is meaningful only while `storeValid` is high and that at most one store completes per cycle. They also assume that `maskMode` is static configuration that changes only between frames. They assume nothing about how often acknowledges arrive, or how many arrive at once. The stimulus always drives a legal index with each store and holds the mask setting for long stretches. Beyond those limits it freely overlaps stores, multi-bit acknowledges, init pulses and reads, including same-buffer store/acknowledge collisions.

// File: rtl/rx_fresh_pkg.sv
package rx_fresh_pkg;
  parameter int NUM_BUFS = 8;
  localparam int IDX_W = $clog2(NUM_BUFS);
  parameter logic [NUM_BUFS-1:0] MASK_CAPABLE = NUM_BUFS'(5);

  typedef logic [NUM_BUFS-1:0] bufVec_t;

  typedef struct packed {
    logic             clrAll;
    bufVec_t          setVec;
    bufVec_t          clrVec;
    bufVec_t          zeroVec;
    logic             irqFire;
    logic [IDX_W-1:0] irqIdx;
    logic             rdLatch;
  } ndCtl_t;
endpackage

// File: rtl/rx_fresh_ctl.sv
module rx_fresh_ctl
  import rx_fresh_pkg::*;
(
  input  logic             initReq,
  input  logic             storeValid,
  input  logic [IDX_W-1:0] storeIdx,
  input  bufVec_t          ackVec,
  input  bufVec_t          maskMode,
  input  logic             rdEn,
  output ndCtl_t           ctl
);
  bufVec_t maskEff;
  bufVec_t setVec;

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_dec
    if (MASK_CAPABLE[b]) begin : g_mask
      assign maskEff[b] = maskMode[b];
    end else begin : g_plain
      assign maskEff[b] = 1'b0;
    end
    assign setVec[b] = storeValid && (storeIdx == IDX_W'(b)) && !maskEff[b];
  end

  always_comb begin
    ctl         = '0;
    ctl.clrAll  = initReq;
    ctl.setVec  = setVec;
    ctl.clrVec  = ackVec;
    ctl.zeroVec = maskEff;
    ctl.irqFire = storeValid && !initReq;
    ctl.irqIdx  = storeIdx;
    ctl.rdLatch = rdEn;
  end
endmodule

// File: rtl/rx_fresh_dp.sv
module rx_fresh_dp
  import rx_fresh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  ndCtl_t           ctl,
  output bufVec_t          newData,
  output bufVec_t          rdData,
  output logic             irqPulse,
  output logic [IDX_W-1:0] irqIdx
);
  bufVec_t flagQ;

  for (genvar b = 0; b < NUM_BUFS; b++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                flagQ[b] <= 1'b0;
      else if (ctl.clrAll)       flagQ[b] <= 1'b0;
      else if (ctl.zeroVec[b])   flagQ[b] <= 1'b0;
      else if (ctl.setVec[b])    flagQ[b] <= 1'b1;
      else if (ctl.clrVec[b])    flagQ[b] <= 1'b0;
    end

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.setVec[b] && !ctl.clrAll |=> flagQ[b]); // R2
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.clrVec[b] && !ctl.setVec[b] |=> !flagQ[b]); // R3
    AST_MASK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.zeroVec[b] |=> !flagQ[b]); // R6
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl.clrAll && !ctl.zeroVec[b] && !ctl.setVec[b] && !ctl.clrVec[b]
      |=> $stable(flagQ[b])); // R4
  end

  assign newData = flagQ & ~ctl.zeroVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData   <= '0;
      irqPulse <= 1'b0;
      irqIdx   <= '0;
    end else begin
      if (ctl.rdLatch) rdData <= newData;
      irqPulse <= ctl.irqFire;
      if (ctl.irqFire) irqIdx <= ctl.irqIdx;
    end
  end

  AST_INIT_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clrAll |=> (flagQ == '0)); // R5
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.irqFire |=> irqPulse && (irqIdx == $past(ctl.irqIdx))); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.irqFire |=> !irqPulse); // R8
  AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.rdLatch |=> (rdData == $past(newData))); // R9
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.rdLatch |=> $stable(rdData)); // R9
endmodule

// File: rtl/rx_fresh_status.sv
module rx_fresh_status
  import rx_fresh_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                initReq,
  input  logic                storeValid,
  input  logic [IDX_W-1:0]    storeIdx,
  input  logic [NUM_BUFS-1:0] ackVec,
  input  logic [NUM_BUFS-1:0] maskMode,
  input  logic                rdEn,
  output logic [NUM_BUFS-1:0] newData,
  output logic [NUM_BUFS-1:0] rdData,
  output logic                irqPulse,
  output logic [IDX_W-1:0]    irqIdx
);
  ndCtl_t ctl;

  rx_fresh_ctl ctl_i (
    .initReq    (initReq),
    .storeValid (storeValid),
    .storeIdx   (storeIdx),
    .ackVec     (ackVec),
    .maskMode   (maskMode),
    .rdEn       (rdEn),
    .ctl        (ctl)
  );

  rx_fresh_dp dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (ctl),
    .newData  (newData),
    .rdData   (rdData),
    .irqPulse (irqPulse),
    .irqIdx   (irqIdx)
  );
endmodule

// File: tb/rx_fresh_status_tb.sv
module rx_fresh_status_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       initReq = 1'b0;
  logic       storeValid = 1'b0;
  logic [2:0] storeIdx = '0;
  logic [7:0] ackVec = '0;
  logic [7:0] maskMode = '0;
  logic       rdEn = 1'b0;
  logic [7:0] newData, rdData;
  logic       irqPulse;
  logic [2:0] irqIdx;

  int compared = 0;
  int mismatched = 0;

  // reference state
  bit [7:0] mFlags = '0;
  bit [7:0] mRd = '0;
  bit       mIrq = 1'b0;
  bit [2:0] mIrqIdx = '0;
  localparam bit [7:0] CAN_MASK = 8'h05;

  always #2.5 clk = ~clk;

  rx_fresh_status dut_i (
    .clk(clk), .rst_n(rst_n), .initReq(initReq), .storeValid(storeValid),
    .storeIdx(storeIdx), .ackVec(ackVec), .maskMode(maskMode), .rdEn(rdEn),
    .newData(newData), .rdData(rdData), .irqPulse(irqPulse), .irqIdx(irqIdx)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit st, input int idx, input bit [7:0] ack,
                      input bit [7:0] msk, input bit ini, input bit rd);
    bit [7:0] eff, nf, vis;
    string tag;
    storeValid = st; storeIdx = 3'(idx); ackVec = ack;
    maskMode = msk; initReq = ini; rdEn = rd;
    eff = msk & CAN_MASK;
    vis = mFlags & ~eff;
    nf = mFlags;
    for (int b = 0; b < 8; b++) begin
      if (ini) nf[b] = 1'b0;
      else if (eff[b]) nf[b] = 1'b0;
      else if (st && idx == b) nf[b] = 1'b1;
      else if (ack[b]) nf[b] = 1'b0;
    end
    if (ini) tag = "R5";
    else if (st && ack[idx]) tag = "R7";
    else if (st) tag = "R2";
    else if (ack != 0) tag = "R3";
    else if (eff != 0) tag = "R6";
    else tag = "R4";
    mIrq = st && !ini;
    if (st && !ini) mIrqIdx = 3'(idx);
    if (rd) mRd = vis;
    @(posedge clk);
    @(negedge clk);
    mFlags = nf;
    chk(newData == (mFlags & ~eff), tag, newData, mFlags & ~eff);
    chk(irqPulse == mIrq, "R8", irqPulse, mIrq);
    if (mIrq) chk(irqIdx == mIrqIdx, "R8", irqIdx, mIrqIdx);
    chk(rdData == mRd, "R9", rdData, mRd);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #200000;
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    bit [7:0] msk;
    repeat (3) @(negedge clk);
    // R5 reset state
    chk(newData == 0, "R5", newData, 0);
    chk(rdData == 0, "R5", rdData, 0);
    chk(irqPulse == 0, "R5", irqPulse, 0);
    chk(irqIdx == 0, "R5", irqIdx, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: several bits set together
    step(1, 1, 0, 0, 0, 0);
    step(1, 3, 0, 0, 0, 0);
    step(1, 5, 0, 0, 0, 0);
    step(1, 7, 0, 0, 0, 1);
    chk(newData == 8'hAA, "R1", newData, 8'hAA);
    step(0, 0, 0, 0, 0, 0);
    chk(rdData == 8'h2A, "R9", rdData, 8'h2A);
    // R3 acknowledge, R7 collision
    step(0, 0, 8'h08, 0, 0, 0);
    step(1, 5, 8'h20, 0, 0, 0);
    step(0, 0, 8'h82, 0, 0, 1);
    // R6 mask mode on buffers 0 and 2, ignored on buffer 1
    step(1, 0, 0, 8'h01, 0, 0);
    step(1, 2, 0, 8'h05, 0, 0);
    step(1, 1, 0, 8'h02, 0, 0);
    step(0, 0, 0, 8'h00, 0, 0);
    step(1, 0, 0, 8'h00, 0, 0);
    step(1, 2, 0, 8'h00, 0, 0);
    step(0, 0, 0, 8'h05, 0, 1);
    step(0, 0, 0, 8'h00, 0, 1);
    // R5 init clears and beats store
    step(1, 6, 0, 0, 1, 0);
    step(0, 0, 0, 0, 0, 1);
    chk(newData == 0, "R5", newData, 0);
    // R4 quiet hold
    step(1, 4, 0, 0, 0, 0);
    repeat (5) step(0, 0, 0, 0, 0, 0);

    msk = '0;
    for (int i = 0; i < 3000; i++) begin
      bit [7:0] ack;
      if ($urandom % 64 == 0) msk = 8'($urandom);
      ack = '0;
      if ($urandom % 3 == 0) ack = 8'(1 << ($urandom % 8));
      if ($urandom % 16 == 0) ack = 8'($urandom);
      step(($urandom % 2) == 0, int'($urandom % 8), ack, msk,
           ($urandom % 60) == 0, ($urandom % 4) == 0);
    end

    summary();
    $finish;
  end
endmodule